// File: doc/BRIEF.md
# Memory-Mapped Bus Address Decoder

This block sits between an 8-bit processor core and the devices of its 16-bit address space. Each read or write request is classified by address into one target: the cartridge port, video RAM, the sprite attribute table, a block of I/O handlers, or storage held inside the block. The internal storage covers the work RAM, the high RAM, the input-port register and the two interrupt registers (pending flags and enables). External targets are reached through a one-hot select strobe plus a shared address, write-data and read/write bus. Each external target returns its byte on its own read-data input. The block merges all of these into one registered read result.

The work RAM and its echo window share one physical array, so a write through either window is seen through the other. The interrupt registers always read with their top three bits set. A write to the input-port register can only change its upper nibble.

A request may ask for a 16-bit word. The block then performs two byte accesses on consecutive cycles, low byte first, and the address wraps past the top of the space. The processor sees `busy` during the second cycle and a single `rvalid` pulse once the whole word has been read.

Top module: `memmap_decoder`

## Requirements
- R1: An access to 0x0000–0x7FFF or 0xA000–0xBFFF raises `sel_cart` in the same cycle, and a read there returns `cart_rdata`.
- R2: An access to 0x8000–0x9FFF raises `sel_vram` and an access to 0xFE00–0xFE9F raises `sel_oam`; reads there return `vram_rdata` and `oam_rdata` respectively.
- R3: 0xC000–0xDFFF (work RAM) and 0xE000–0xFDFF (echo) address one array. The index is address bits [12:0] folded to `WRAM_AW` bits, so a byte written through one window reads back through the other at the same offset.
- R4: The pending-flag register (0xFF0F) and the enable register (0xFFFF) read as their stored value ORed with 0xE0. After reset they hold 0xE1 and 0x00.
- R5: The input-port register at 0xFF00 resets to 0xCF. A write there changes only bits 7:4, and bits 3:0 keep their value.
- R6: 0xFF80–0xFFFE is high RAM, indexed by address bits [6:0], and reads back what was written.
- R7: 0xFEA0–0xFEFF raises no select, reads as 0xFF, and a write there changes no stored byte.
- R8: An access to 0xFF01–0xFF7F, other than 0xFF0F, raises `sel_io`, and a read there returns `io_rdata`.
- R9: At most one of `sel_cart`, `sel_vram`, `sel_oam` and `sel_io` is high in any cycle, and none is high without an access.
- R10: A byte read loads the addressed byte into `rdata[7:0]` and zero into `rdata[15:8]` at the next clock edge, with `rvalid` high for that one cycle.
- R11: A word access covers the address in its first cycle and address+1 (mod 2^16) in the second, with `busy` high for exactly that second cycle. A word read returns the low byte in `rdata[7:0]` and the high byte in `rdata[15:8]`, with `rvalid` one cycle after the second byte. A word write stores `req_wdata[7:0]` then `req_wdata[15:8]`. Requests presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request |
| req_word | input | 1 | Request is a 16-bit word access |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Write data, low byte in [7:0] |
| rdata | output | 16 | Registered read result |
| rvalid | output | 1 | Read result valid for one cycle |
| busy | output | 1 | Second byte of a word access in progress |
| tgt_rd | output | 1 | Read on the target bus this cycle |
| tgt_wr | output | 1 | Write on the target bus this cycle |
| tgt_addr | output | 16 | Target bus address |
| tgt_wdata | output | 8 | Target bus write byte |
| sel_cart | output | 1 | Cartridge port select |
| sel_vram | output | 1 | Video RAM select |
| sel_oam | output | 1 | Sprite attribute table select |
| sel_io | output | 1 | I/O handler select |
| cart_rdata | input | 8 | Cartridge read byte |
| vram_rdata | input | 8 | Video RAM read byte |
| oam_rdata | input | 8 | Sprite attribute read byte |
| io_rdata | input | 8 | I/O handler read byte |

## Verification
The assertions take for granted that `req_rd` and `req_wr` are never high together, and one property checks that assumption at the inputs. They also assume each external target returns its byte combinationally in the cycle it is selected. The stimulus chooses exactly one operation per request and drops both strobes between requests. The bench models every target as a fixed function of `tgt_addr`, and it only issues a new request once the previous word access has left its busy cycle. The one exception is a deliberate request made during `busy`, which exercises the rule that such requests are ignored.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

   typedef enum logic [3:0] {
      RG_CART,
      RG_VRAM,
      RG_OAM,
      RG_WRAM,
      RG_DEAD,
      RG_PAD,
      RG_IFLAG,
      RG_IO,
      RG_HRAM,
      RG_IEN
   } region_e;

   localparam logic [15:0] VRAM_LO  = 16'h8000;
   localparam logic [15:0] XRAM_LO  = 16'hA000;
   localparam logic [15:0] WRAM_LO  = 16'hC000;
   localparam logic [15:0] OAM_LO   = 16'hFE00;
   localparam logic [15:0] DEAD_LO  = 16'hFEA0;
   localparam logic [15:0] IO_LO    = 16'hFF00;
   localparam logic [15:0] HRAM_LO  = 16'hFF80;
   localparam logic [15:0] PAD_ADR  = 16'hFF00;
   localparam logic [15:0] IFLG_ADR = 16'hFF0F;
   localparam logic [15:0] IEN_ADR  = 16'hFFFF;

   localparam logic [7:0] IRQ_PAD_BITS = 8'hE0;

   function automatic region_e decode_region(input logic [15:0] a);
      region_e r;
      if (a < VRAM_LO)        r = RG_CART;
      else if (a < XRAM_LO)   r = RG_VRAM;
      else if (a < WRAM_LO)   r = RG_CART;
      else if (a < OAM_LO)    r = RG_WRAM;
      else if (a < DEAD_LO)   r = RG_OAM;
      else if (a < IO_LO)     r = RG_DEAD;
      else if (a == PAD_ADR)  r = RG_PAD;
      else if (a == IFLG_ADR) r = RG_IFLAG;
      else if (a < HRAM_LO)   r = RG_IO;
      else if (a == IEN_ADR)  r = RG_IEN;
      else                    r = RG_HRAM;
      return r;
   endfunction

endpackage

// File: rtl/memmap_region_dec.sv
module memmap_region_dec
   import memmap_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              active,
   output region_e           region,
   output logic              sel_cart,
   output logic              sel_vram,
   output logic              sel_oam,
   output logic              sel_io
);

   generate
      if (ADDR_W != 16) begin : g_bad_aw
         $error("memmap_region_dec: ADDR_W must be 16");
      end
   endgenerate

   always_comb begin
      region   = decode_region(addr);
      sel_cart = active && (region == RG_CART);
      sel_vram = active && (region == RG_VRAM);
      sel_oam  = active && (region == RG_OAM);
      sel_io   = active && (region == RG_IO);
   end

endmodule

// File: rtl/memmap_word_seq.sv
module memmap_word_seq #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_rd,
   input  logic                req_wr,
   input  logic                req_word,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [2*DATA_W-1:0] req_wdata,
   output logic                cur_rd,
   output logic                cur_wr,
   output logic [ADDR_W-1:0]   cur_addr,
   output logic [DATA_W-1:0]   cur_wdata,
   output logic                busy
);

   logic              pend_rd, pend_wr;
   logic [ADDR_W-1:0] pend_addr;
   logic [DATA_W-1:0] pend_hi;
   logic              start_word;

   assign start_word = !busy && req_word && (req_rd || req_wr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         pend_rd   <= 1'b0;
         pend_wr   <= 1'b0;
         pend_addr <= '0;
         pend_hi   <= '0;
      end else begin
         busy <= start_word;
         if (start_word) begin
            pend_rd   <= req_rd;
            pend_wr   <= req_wr;
            pend_addr <= req_addr + 1'b1;
            pend_hi   <= req_wdata[2*DATA_W-1:DATA_W];
         end
      end
   end

   always_comb begin
      if (busy) begin
         cur_rd    = pend_rd;
         cur_wr    = pend_wr;
         cur_addr  = pend_addr;
         cur_wdata = pend_hi;
      end else begin
         cur_rd    = req_rd;
         cur_wr    = req_wr;
         cur_addr  = req_addr;
         cur_wdata = req_wdata[DATA_W-1:0];
      end
   end

endmodule

// File: rtl/memmap_local_store.sv
module memmap_local_store
   import memmap_pkg::*;
#(
   parameter int         DATA_W    = 8,
   parameter int         WRAM_AW   = 11,
   parameter int         HRAM_AW   = 7,
   parameter logic [7:0] IF_RESET  = 8'hE1,
   parameter logic [7:0] IE_RESET  = 8'h00,
   parameter logic [7:0] PAD_RESET = 8'hCF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  region_e            region,
   input  logic [WRAM_AW-1:0] wram_idx,
   input  logic [HRAM_AW-1:0] hram_idx,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  local_rd
);

   localparam int WRAM_DEPTH = 1 << WRAM_AW;
   localparam int HRAM_DEPTH = 1 << HRAM_AW;
   localparam int NIB        = DATA_W / 2;

   generate
      if (WRAM_AW < 1 || WRAM_AW > 13) begin : g_bad_wram
         $error("memmap_local_store: WRAM_AW must lie in 1..13");
      end
      if (HRAM_AW != 7) begin : g_bad_hram
         $error("memmap_local_store: HRAM_AW must be 7");
      end
      if (DATA_W != 8) begin : g_bad_dw
         $error("memmap_local_store: DATA_W must be 8");
      end
   endgenerate

   logic [DATA_W-1:0] wram [WRAM_DEPTH];
   logic [DATA_W-1:0] hram [HRAM_DEPTH];
   logic [DATA_W-1:0] iflag_q, ien_q, pad_q;

   always_ff @(posedge clk) begin
      if (wr && region == RG_WRAM) wram[wram_idx] <= wdata;
      if (wr && region == RG_HRAM) hram[hram_idx] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iflag_q <= IF_RESET;
         ien_q   <= IE_RESET;
         pad_q   <= PAD_RESET;
      end else if (wr) begin
         if (region == RG_IFLAG) iflag_q <= wdata;
         if (region == RG_IEN)   ien_q   <= wdata;
         if (region == RG_PAD)   pad_q   <= {wdata[DATA_W-1:NIB], pad_q[NIB-1:0]};
      end
   end

   always_comb begin
      case (region)
         RG_WRAM:  local_rd = wram[wram_idx];
         RG_HRAM:  local_rd = hram[hram_idx];
         RG_IFLAG: local_rd = iflag_q | IRQ_PAD_BITS;
         RG_IEN:   local_rd = ien_q | IRQ_PAD_BITS;
         RG_PAD:   local_rd = pad_q;
         default:  local_rd = '1;
      endcase
   end

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
   import memmap_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int WRAM_AW = 11,
   parameter int HRAM_AW = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_rd,
   input  logic                req_wr,
   input  logic                req_word,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [2*DATA_W-1:0] req_wdata,
   output logic [2*DATA_W-1:0] rdata,
   output logic                rvalid,
   output logic                busy,
   output logic                tgt_rd,
   output logic                tgt_wr,
   output logic [ADDR_W-1:0]   tgt_addr,
   output logic [DATA_W-1:0]   tgt_wdata,
   output logic                sel_cart,
   output logic                sel_vram,
   output logic                sel_oam,
   output logic                sel_io,
   input  logic [DATA_W-1:0]   cart_rdata,
   input  logic [DATA_W-1:0]   vram_rdata,
   input  logic [DATA_W-1:0]   oam_rdata,
   input  logic [DATA_W-1:0]   io_rdata
);

   localparam int LANES = 2;

   region_e           region;
   logic [DATA_W-1:0] local_rd;
   logic [DATA_W-1:0] rd_byte;
   logic [DATA_W-1:0] lane_q [LANES];

   memmap_word_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_rd    (req_rd),
      .req_wr    (req_wr),
      .req_word  (req_word),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .cur_rd    (tgt_rd),
      .cur_wr    (tgt_wr),
      .cur_addr  (tgt_addr),
      .cur_wdata (tgt_wdata),
      .busy      (busy)
   );

   memmap_region_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr     (tgt_addr),
      .active   (tgt_rd || tgt_wr),
      .region   (region),
      .sel_cart (sel_cart),
      .sel_vram (sel_vram),
      .sel_oam  (sel_oam),
      .sel_io   (sel_io)
   );

   memmap_local_store #(
      .DATA_W  (DATA_W),
      .WRAM_AW (WRAM_AW),
      .HRAM_AW (HRAM_AW)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (tgt_wr),
      .region   (region),
      .wram_idx (tgt_addr[WRAM_AW-1:0]),
      .hram_idx (tgt_addr[HRAM_AW-1:0]),
      .wdata    (tgt_wdata),
      .local_rd (local_rd)
   );

   always_comb begin
      case (region)
         RG_CART: rd_byte = cart_rdata;
         RG_VRAM: rd_byte = vram_rdata;
         RG_OAM:  rd_byte = oam_rdata;
         RG_IO:   rd_byte = io_rdata;
         default: rd_byte = local_rd;
      endcase
   end

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_q[l] <= '0;
            end else if (tgt_rd) begin
               if (busy == (l == 1)) lane_q[l] <= rd_byte;
               else if (!busy)       lane_q[l] <= '0;
            end
         end
         assign rdata[l*DATA_W +: DATA_W] = lane_q[l];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rvalid <= 1'b0;
      else        rvalid <= tgt_rd && (busy || !req_word);
   end

endmodule

// File: rtl/memmap_decoder_chk.sv
module memmap_decoder_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_rd,
   input logic        req_wr,
   input logic        req_word,
   input logic [15:0] rdata,
   input logic        rvalid,
   input logic        busy,
   input logic        tgt_rd,
   input logic        tgt_wr,
   input logic [15:0] tgt_addr,
   input logic        sel_cart,
   input logic        sel_vram,
   input logic        sel_oam,
   input logic        sel_io
);

   // R9: input assumption, read and write never requested together
   a_r9_ops_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_rd && req_wr));

   a_r9_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_cart, sel_vram, sel_oam, sel_io}));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(tgt_rd || tgt_wr) |-> !(sel_cart || sel_vram || sel_oam || sel_io));

   a_r1_cart_range: assert property (@(posedge clk) disable iff (!rst_n)
      sel_cart |-> (tgt_addr < 16'h8000 || (tgt_addr >= 16'hA000 && tgt_addr < 16'hC000)));

   a_r7_dead_nosel: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_addr >= 16'hFEA0 && tgt_addr < 16'hFF00) |->
         !(sel_cart || sel_vram || sel_oam || sel_io));

   a_r11_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   a_r11_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> tgt_addr == $past(tgt_addr) + 16'd1);

   a_r4_irq_high_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_rd && !busy && (tgt_addr == 16'hFF0F || tgt_addr == 16'hFFFF)) |=>
         rdata[7:5] == 3'b111);

   a_r10_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_rd && (busy || !req_word)) |=> rvalid);

endmodule

bind memmap_decoder memmap_decoder_chk u_chk (.*);

// File: tb/sim_memmap_decoder.sv
module sim_memmap_decoder;

   localparam int WA = 11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_rd = 1'b0, req_wr = 1'b0, req_word = 1'b0;
   logic [15:0] req_addr = '0, req_wdata = '0;
   logic [15:0] rdata, tgt_addr;
   logic        rvalid, busy, tgt_rd, tgt_wr;
   logic [7:0]  tgt_wdata, cart_rdata, vram_rdata, oam_rdata, io_rdata;
   logic        sel_cart, sel_vram, sel_oam, sel_io;

   always #5 clk = ~clk;

   assign cart_rdata = tgt_addr[7:0] ^ 8'h3C;
   assign vram_rdata = tgt_addr[7:0] ^ 8'hA5;
   assign oam_rdata  = tgt_addr[7:0] ^ 8'h5A;
   assign io_rdata   = tgt_addr[7:0] + 8'h11;

   memmap_decoder #(.WRAM_AW(WA)) u0 (
      .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .req_word(req_word),
      .req_addr(req_addr), .req_wdata(req_wdata), .rdata(rdata), .rvalid(rvalid),
      .busy(busy), .tgt_rd(tgt_rd), .tgt_wr(tgt_wr), .tgt_addr(tgt_addr),
      .tgt_wdata(tgt_wdata), .sel_cart(sel_cart), .sel_vram(sel_vram),
      .sel_oam(sel_oam), .sel_io(sel_io), .cart_rdata(cart_rdata),
      .vram_rdata(vram_rdata), .oam_rdata(oam_rdata), .io_rdata(io_rdata)
   );

   int n_chk = 0, n_bad = 0;
   logic [7:0] m_wram [1<<WA];
   logic [7:0] m_hram [128];
   logic [7:0] m_if = 8'hE1, m_ie = 8'h00, m_pad = 8'hCF;

   // 0 cart,1 vram,2 oam,3 wram,4 dead,5 pad,6 iflag,7 io,8 hram,9 ien
   function automatic int rg(input logic [15:0] a);
      if (a <= 16'h7FFF || (a >= 16'hA000 && a <= 16'hBFFF)) return 0;
      if (a <= 16'h9FFF) return 1;
      if (a <= 16'hFDFF) return 3;
      if (a <= 16'hFE9F) return 2;
      if (a <= 16'hFEFF) return 4;
      if (a == 16'hFF00) return 5;
      if (a == 16'hFF0F) return 6;
      if (a <= 16'hFF7F) return 7;
      if (a == 16'hFFFF) return 9;
      return 8;
   endfunction

   function automatic string tag_of(input logic [15:0] a);
      case (rg(a))
         0: return "R1";
         1, 2: return "R2";
         3: return "R3";
         4: return "R7";
         5: return "R5";
         6, 9: return "R4";
         7: return "R8";
         default: return "R6";
      endcase
   endfunction

   function automatic logic [3:0] sel_exp(input logic [15:0] a);
      case (rg(a))
         0: return 4'b1000;
         1: return 4'b0100;
         2: return 4'b0010;
         7: return 4'b0001;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic logic [7:0] exp_rd(input logic [15:0] a);
      case (rg(a))
         0: return a[7:0] ^ 8'h3C;
         1: return a[7:0] ^ 8'hA5;
         2: return a[7:0] ^ 8'h5A;
         3: return m_wram[a[WA-1:0]];
         4: return 8'hFF;
         5: return m_pad;
         6: return m_if | 8'hE0;
         7: return a[7:0] + 8'h11;
         9: return m_ie | 8'hE0;
         default: return m_hram[a[6:0]];
      endcase
   endfunction

   task automatic model_wr(input logic [15:0] a, input logic [7:0] d);
      case (rg(a))
         3: m_wram[a[WA-1:0]] = d;
         5: m_pad = {d[7:4], m_pad[3:0]};
         6: m_if = d;
         8: m_hram[a[6:0]] = d;
         9: m_ie = d;
         default: ;
      endcase
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic access(input bit wr, input bit word, input logic [15:0] a,
                         input logic [15:0] d);
      logic [7:0] lo, hi;
      logic [15:0] a1;
      a1 = a + 16'd1;
      @(negedge clk);
      req_rd = !wr; req_wr = wr; req_word = word; req_addr = a; req_wdata = d;
      #1;
      chk({tag_of(a), " select"}, {sel_cart, sel_vram, sel_oam, sel_io}, sel_exp(a));
      if (wr) model_wr(a, d[7:0]);
      else lo = exp_rd(a);
      @(posedge clk);
      @(negedge clk);
      req_rd = 1'b0; req_wr = 1'b0; req_word = 1'b0;
      if (word) begin
         #1;
         chk("R11 busy", busy, 1);
         chk("R11 step", tgt_addr, a1);
         chk({tag_of(a1), " R11 select"}, {sel_cart, sel_vram, sel_oam, sel_io}, sel_exp(a1));
         if (wr) model_wr(a1, d[15:8]);
         else hi = exp_rd(a1);
         @(posedge clk);
         @(negedge clk);
      end
      #1;
      chk("R11 busy clear", busy, 0);
      if (!wr) begin
         chk(word ? "R11 rvalid" : "R10 rvalid", rvalid, 1);
         if (word) chk("R11 word data", rdata, {hi, lo});
         else      chk({tag_of(a), " R10 data"}, rdata, {8'h00, lo});
      end else begin
         chk("R10 no rvalid on write", rvalid, 0);
      end
   endtask

   function automatic logic [15:0] pick_addr(input int b);
      case (b)
         0: return 16'($urandom % 32'h8000);
         1: return 16'h8000 + 16'($urandom % 32'h2000);
         2: return 16'hA000 + 16'($urandom % 32'h2000);
         3: return 16'hC000 + 16'($urandom % 32'h2000);
         4: return 16'hE000 + 16'($urandom % 32'h1E00);
         5: return 16'hFE00 + 16'($urandom % 32'hA0);
         6: return 16'hFEA0 + 16'($urandom % 32'h60);
         7: return 16'hFF00 + 16'($urandom % 32'h80);
         8: return 16'hFF80 + 16'($urandom % 32'h7F);
         default: begin
            case ($urandom % 3)
               0: return 16'hFF00;
               1: return 16'hFF0F;
               default: return 16'hFFFF;
            endcase
         end
      endcase
   endfunction

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      int seed;
      seed = $urandom(32'h00C0FFEE);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // reset state
      chk("R10 reset rvalid", rvalid, 0);
      chk("R11 reset busy", busy, 0);
      chk("R10 reset rdata", rdata, 0);
      chk("R9 reset selects", {sel_cart, sel_vram, sel_oam, sel_io}, 0);
      access(0, 0, 16'hFF0F, 0);
      chk("R4 flag reset value", rdata, 16'h00E1);
      access(0, 0, 16'hFFFF, 0);
      chk("R4 enable reset value", rdata, 16'h00E0);
      access(0, 0, 16'hFF00, 0);
      chk("R5 port reset value", rdata, 16'h00CF);

      // fill local arrays
      for (int i = 0; i < (1 << WA); i++)
         access(1, 0, 16'hC000 + 16'(i), 16'((i * 37 + 5) & 8'hFF));
      for (int i = 0; i < 127; i++)
         access(1, 0, 16'hFF80 + 16'(i), 16'((i * 11 + 3) & 8'hFF));

      // directed corners
      access(1, 0, 16'hFF00, 16'h0000);
      access(0, 0, 16'hFF00, 0);
      chk("R5 lower nibble kept", rdata, 16'h000F);
      access(1, 0, 16'hFF0F, 16'h0003);
      access(0, 0, 16'hFF0F, 0);
      chk("R4 flag forced bits", rdata, 16'h00E3);
      access(1, 0, 16'hC123, 16'h005A);
      access(0, 0, 16'hE123, 0);
      chk("R3 echo sees work write", rdata, 16'h005A);
      access(1, 0, 16'hFD00, 16'h00A7);
      access(0, 0, 16'hDD00, 0);
      chk("R3 work sees echo write", rdata, 16'h00A7);
      access(1, 0, 16'hFEA5, 16'h0099);
      access(0, 0, 16'hFEA5, 0);
      access(0, 0, 16'hC0A5, 0);
      access(0, 0, 16'hFFA5, 0);
      access(1, 1, 16'hFFFF, 16'h1234);
      access(0, 1, 16'hFFFF, 0);
      chk("R11 wrap word", rdata, 16'h3CF4);
      access(0, 1, 16'hFF80, 0);

      // request during busy is ignored
      access(1, 0, 16'hFF90, 16'h0011);
      @(negedge clk);
      req_rd = 1; req_word = 1; req_addr = 16'hFF80;
      @(posedge clk);
      @(negedge clk);
      req_rd = 0; req_word = 0; req_wr = 1; req_addr = 16'hFF90; req_wdata = 16'h0099;
      @(posedge clk);
      @(negedge clk);
      req_wr = 0;
      access(0, 0, 16'hFF90, 0);
      chk("R11 request during busy ignored", rdata, 16'h0011);

      // constrained random
      for (int n = 0; n < 1500; n++) begin
         int b;
         bit w, wd;
         b  = int'($urandom % 10);
         w  = $urandom % 2;
         wd = ($urandom % 4) == 0;
         access(w, wd, pick_addr(b), 16'($urandom));
      end

      finish_run();
   end

endmodule